// File: doc/BRIEF.md
# SPI Status-Bit Auto-Poll Engine

This engine watches a single bit of a SPI device's status byte with no processor in the loop. A typical use is waiting for a flash write-in-progress flag to clear. Software writes one control word that holds a command byte, a 4-bit timeout exponent, a bit offset, the bit value to wait for and a start flag. On each try the engine selects the device, sends the command, collects one response byte, releases the select line and tests the chosen bit. The run ends on the first match, or when the try budget is used up. Each outcome raises its own interrupt source, and every try also raises a transfer-end source.

The byte shifter and SPI clock setting belong to the host controller. Here the shifter appears as a byte-transfer handshake: a one-cycle start pulse with the byte to send, then a done pulse with the byte received. The host's clock select enters the try budget, which is `31 << (clock_select + timeout)`, capped at a shift of `MAX_SHIFT`.

Top module: `spi_autopoll`

## Requirements
- R1: After reset `cs_n` is 1, `xfer_start` is 0, `int_stat` is 0, `irq` is 0 and `cfg_rd` reads 0.
- R2: A `cfg_we` write while idle with bit 31 set starts a run. The word's fields are: command in bits 7:0, timeout in bits 19:16, bit offset in bits 26:24 and compare value in bit 30. Each try pulses `xfer_start` with `cs_n` low and `xfer_tx` equal to the command. `cfg_rd` returns the same field positions, with bit 31 reading 1 while a run is active.
- R3: When `xfer_done` arrives, bit `offset` of `xfer_rx` is compared with the compare value. On equality `int_stat` bit 1 is set, no further try starts, and `cfg_rd` bit 31 reads 0 one cycle later.
- R4: A run makes at most `31 << min(clk_sel + timeout, MAX_SHIFT)` tries, using the `clk_sel` value sampled at start. If the last try does not match, `int_stat` bit 2 is set and the run stops. A match on the last try sets bit 1 and not bit 2.
- R5: `int_stat` bit 0 is set after every completed try, including the last one.
- R6: `cs_n` returns high for at least one cycle between two tries of the same run.
- R7: A write with bit 31 set during a run is ignored. The command, offset, compare value and try budget stay unchanged, and the try count is not restarted.
- R8: `irq` is the OR of the `int_stat` bits whose `int_mask` bit is 0. A mask bit of 1 disables its source.
- R9: Writing 1 to an `int_ack` bit clears that status bit. If a new event for the same bit occurs in the same cycle, the bit stays set.
- R10: A write while idle with bit 31 clear updates the stored fields and starts no try.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Host SPI clock select, part of the try budget |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rd | output | 32 | Control word readback, bit 31 is the run flag |
| int_mask | input | 3 | Interrupt disable per source (1 = disabled) |
| int_ack | input | 3 | Write-1-to-clear status acknowledge |
| int_stat | output | 3 | Status: bit 0 try done, bit 1 match, bit 2 timeout |
| irq | output | 1 | Interrupt request |
| cs_n | output | 1 | Device select, active low |
| xfer_start | output | 1 | One-cycle request to the byte shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Shifter completion pulse |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |

## Verification
Two events can land on the same clock edge: a status event and its acknowledge. A try-done event, or the final match, can arrive in the same cycle that software writes 1 to clear that same bit. The bench's shifter model can raise the acknowledge for all three sources together with `xfer_done`. The bench then reads `int_stat` in the next cycle and requires the bit to be set, so the event wins over the acknowledge. Random runs also combine a match on the very last try with the timeout decision, and require the match source alone.

// File: rtl/spi_ap_pkg.sv
package spi_ap_pkg;
   localparam int AP_CMD_W      = 8;
   localparam int AP_TMO_W      = 4;
   localparam int AP_OFF_W      = 3;
   localparam int AP_CMD_LSB    = 0;
   localparam int AP_TMO_LSB    = 16;
   localparam int AP_OFF_LSB    = 24;
   localparam int AP_CMP_BIT    = 30;
   localparam int AP_GO_BIT     = 31;
   localparam int AP_NSRC       = 3;
   localparam int AP_SRC_TRAN   = 0;
   localparam int AP_SRC_MATCH  = 1;
   localparam int AP_SRC_TMO    = 2;
   localparam int AP_BASE_TRIES = 31;
   localparam int AP_BASE_W     = 5;

   typedef enum logic [2:0] {
      AP_IDLE = 3'd0,
      AP_SEL  = 3'd1,
      AP_XFER = 3'd2,
      AP_WAIT = 3'd3,
      AP_GAP  = 3'd4
   } ap_state_t;

   typedef struct packed {
      logic                cmp;
      logic [AP_OFF_W-1:0] off;
      logic [AP_TMO_W-1:0] tmo;
      logic [AP_CMD_W-1:0] cmd;
   } ap_cfg_t;
endpackage

// File: rtl/spi_ap_budget.sv
module spi_ap_budget
   import spi_ap_pkg::*;
#(
   parameter int CLKSEL_W  = 3,
   parameter int MAX_SHIFT = 20,
   localparam int CNT_W    = AP_BASE_W + MAX_SHIFT
) (
   input  logic [CLKSEL_W-1:0] clk_sel,
   input  logic [AP_TMO_W-1:0] tmo,
   output logic [CNT_W-1:0]    limit
);
   localparam int SUM_W = ((CLKSEL_W > AP_TMO_W) ? CLKSEL_W : AP_TMO_W) + 1;

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] shift;

   assign sum = SUM_W'(clk_sel) + SUM_W'(tmo);

   generate
      if (MAX_SHIFT >= (1 << SUM_W) - 1) begin : g_no_clamp
         assign shift = sum;
      end else begin : g_clamp
         assign shift = (int'(sum) > MAX_SHIFT) ? SUM_W'(MAX_SHIFT) : sum;
      end
   endgenerate

   assign limit = CNT_W'(AP_BASE_TRIES) << shift;

   initial begin
      assert (MAX_SHIFT >= 1 && MAX_SHIFT <= 26);
      assert (CLKSEL_W >= 1 && CLKSEL_W <= 4);
   end
endmodule

// File: rtl/spi_ap_seq.sv
module spi_ap_seq
   import spi_ap_pkg::*;
#(
   parameter int CNT_W = 25
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic [CNT_W-1:0]    limit_in,
   input  logic [AP_CMD_W-1:0] cmd,
   input  logic [AP_OFF_W-1:0] off,
   input  logic                cmp,
   input  logic                xfer_done,
   input  logic [AP_CMD_W-1:0] xfer_rx,
   output logic                busy,
   output logic                cs_n,
   output logic                xfer_start,
   output logic [AP_CMD_W-1:0] xfer_tx,
   output logic                ev_tran,
   output logic                ev_match,
   output logic                ev_tmo
);
   ap_state_t        st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim_q;
   logic             hit;
   logic             last;

   assign hit  = (xfer_rx[off] == cmp);
   assign last = (cnt == lim_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= AP_IDLE;
         cnt   <= '0;
         lim_q <= '0;
      end else begin
         unique case (st)
            AP_IDLE: if (go) begin
               st    <= AP_SEL;
               cnt   <= '0;
               lim_q <= limit_in;
            end
            AP_SEL:  st <= AP_XFER;
            AP_XFER: st <= AP_WAIT;
            AP_WAIT: if (xfer_done) begin
               cnt <= cnt + CNT_W'(1);
               st  <= (hit || last) ? AP_IDLE : AP_GAP;
            end
            AP_GAP:  st <= AP_SEL;
            default: st <= AP_IDLE;
         endcase
      end
   end

   assign busy       = (st != AP_IDLE);
   assign cs_n       = !((st == AP_SEL) || (st == AP_XFER) || (st == AP_WAIT));
   assign xfer_start = (st == AP_XFER);
   assign xfer_tx    = cmd;
   assign ev_tran    = (st == AP_WAIT) && xfer_done;
   assign ev_match   = ev_tran && hit;
   assign ev_tmo     = ev_tran && !hit && last;

   assert_start_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> !cs_n);
   assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);
   assert_stop_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_match |=> !busy);
   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt < lim_q));
   assert_stop_on_tmo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tmo |=> !busy);
   assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tran && !ev_match && !ev_tmo) |=> cs_n);
   assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && go) |=> $stable(lim_q));
endmodule

// File: rtl/spi_ap_irq.sv
module spi_ap_irq #(
   parameter int NSRC     = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] ev,
   input  logic [NSRC-1:0] ack,
   input  logic [NSRC-1:0] mask,
   output logic [NSRC-1:0] stat,
   output logic            irq
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     stat[i] <= 1'b0;
            else if (ev[i]) stat[i] <= 1'b1;
            else if (ack[i]) stat[i] <= 1'b0;
         end
         assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> stat[i]);
      end else begin : g_ack_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stat[i] <= 1'b0;
            else if (ack[i]) stat[i] <= 1'b0;
            else if (ev[i])  stat[i] <= 1'b1;
         end
      end
      assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (ack[i] && !ev[i]) |=> !stat[i]);
   end

   assign irq = |(stat & ~mask);

   initial assert (NSRC >= 1);
endmodule

// File: rtl/spi_autopoll.sv
module spi_autopoll
   import spi_ap_pkg::*;
#(
   parameter int CLKSEL_W  = 3,
   parameter int MAX_SHIFT = 20,
   parameter bit SET_WINS  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CLKSEL_W-1:0] clk_sel,
   input  logic                cfg_we,
   input  logic [31:0]         cfg_wdata,
   output logic [31:0]         cfg_rd,
   input  logic [AP_NSRC-1:0]  int_mask,
   input  logic [AP_NSRC-1:0]  int_ack,
   output logic [AP_NSRC-1:0]  int_stat,
   output logic                irq,
   output logic                cs_n,
   output logic                xfer_start,
   output logic [AP_CMD_W-1:0] xfer_tx,
   input  logic                xfer_done,
   input  logic [AP_CMD_W-1:0] xfer_rx
);
   localparam int CNT_W = AP_BASE_W + MAX_SHIFT;

   ap_cfg_t            cfg_q;
   ap_cfg_t            cfg_new;
   logic               busy;
   logic               go;
   logic [CNT_W-1:0]   limit;
   logic               ev_tran, ev_match, ev_tmo;
   logic [AP_NSRC-1:0] ev;
   logic               unused_wbits;

   assign cfg_new.cmd = cfg_wdata[AP_CMD_LSB +: AP_CMD_W];
   assign cfg_new.tmo = cfg_wdata[AP_TMO_LSB +: AP_TMO_W];
   assign cfg_new.off = cfg_wdata[AP_OFF_LSB +: AP_OFF_W];
   assign cfg_new.cmp = cfg_wdata[AP_CMP_BIT];
   assign go          = cfg_we && cfg_wdata[AP_GO_BIT];
   assign unused_wbits = ^{cfg_wdata[29:27], cfg_wdata[23:20], cfg_wdata[15:8]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cfg_q <= '0;
      else if (cfg_we && !busy)  cfg_q <= cfg_new;
   end

   always_comb begin
      cfg_rd = '0;
      cfg_rd[AP_CMD_LSB +: AP_CMD_W] = cfg_q.cmd;
      cfg_rd[AP_TMO_LSB +: AP_TMO_W] = cfg_q.tmo;
      cfg_rd[AP_OFF_LSB +: AP_OFF_W] = cfg_q.off;
      cfg_rd[AP_CMP_BIT]             = cfg_q.cmp;
      cfg_rd[AP_GO_BIT]              = busy;
   end

   spi_ap_budget #(
      .CLKSEL_W  (CLKSEL_W),
      .MAX_SHIFT (MAX_SHIFT)
   ) u_budget (
      .clk_sel (clk_sel),
      .tmo     (cfg_new.tmo),
      .limit   (limit)
   );

   spi_ap_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .limit_in   (limit),
      .cmd        (cfg_q.cmd),
      .off        (cfg_q.off),
      .cmp        (cfg_q.cmp),
      .xfer_done  (xfer_done),
      .xfer_rx    (xfer_rx),
      .busy       (busy),
      .cs_n       (cs_n),
      .xfer_start (xfer_start),
      .xfer_tx    (xfer_tx),
      .ev_tran    (ev_tran),
      .ev_match   (ev_match),
      .ev_tmo     (ev_tmo)
   );

   always_comb begin
      ev               = '0;
      ev[AP_SRC_TRAN]  = ev_tran;
      ev[AP_SRC_MATCH] = ev_match;
      ev[AP_SRC_TMO]   = ev_tmo;
   end

   spi_ap_irq #(
      .NSRC     (AP_NSRC),
      .SET_WINS (SET_WINS)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .ack   (int_ack),
      .mask  (int_mask),
      .stat  (int_stat),
      .irq   (irq)
   );

   assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && busy) |=> $stable(cfg_q));
   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n && !xfer_start));
   assert_write_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_wdata[AP_GO_BIT] && !busy) |=> !busy);
endmodule

// File: tb/tb_spi_autopoll.sv
module tb_spi_autopoll;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  clk_sel = '0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rd;
   logic [2:0]  int_mask = '0;
   logic [2:0]  ack_main = '0;
   logic [2:0]  ack_model = '0;
   logic [2:0]  int_ack;
   logic [2:0]  int_stat;
   logic        irq;
   logic        cs_n;
   logic        xfer_start;
   logic [7:0]  xfer_tx;
   logic        xfer_done = 1'b0;
   logic [7:0]  xfer_rx = '0;

   int total = 0;
   int fails = 0;
   int tries, match_at, exp_off, tx_bad, gap_bad, tran_bad;
   logic [7:0] exp_cmd;
   bit exp_cmp, cs_hi_seen, same_ack;

   assign int_ack = ack_main | ack_model;

   always #5 clk = ~clk;

   spi_autopoll dut (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .int_mask(int_mask),
      .int_ack(int_ack), .int_stat(int_stat), .irq(irq), .cs_n(cs_n),
      .xfer_start(xfer_start), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
      .xfer_rx(xfer_rx)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pack_word(input bit go, input bit cmp,
         input logic [2:0] off, input logic [3:0] tmo, input logic [7:0] cmd);
      return {go, cmp, 3'b000, off, 4'b0000, tmo, 8'h00, cmd};
   endfunction

   function automatic int budget_of(input int cs, input int tmo);
      int s = cs + tmo;
      if (s > 20) s = 20;
      return 31 << s;
   endfunction

   // Shifter model: answers each request, checks select and command per try.
   initial begin
      forever begin
         @(negedge clk);
         if (cs_n) cs_hi_seen = 1'b1;
         if (xfer_start) begin
            tries++;
            if (xfer_tx !== exp_cmd) tx_bad++;
            if (tries > 1 && !cs_hi_seen) gap_bad++;
            cs_hi_seen = 1'b0;
            repeat ($urandom_range(1, 4)) @(negedge clk);
            xfer_done = 1'b1;
            xfer_rx = 8'($urandom);
            xfer_rx[exp_off] = (tries == match_at) ? exp_cmp : ~exp_cmp;
            if (same_ack) ack_model = 3'b111;
            @(negedge clk);
            xfer_done = 1'b0;
            ack_model = 3'b000;
            if (cs_n) cs_hi_seen = 1'b1;
            if (!int_stat[0]) tran_bad++;
            if (cfg_rd[31]) begin
               ack_model = 3'b001;
               @(negedge clk);
               ack_model = 3'b000;
            end
         end
      end
   end

   task automatic write_cfg(input logic [31:0] w);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic prime(input logic [7:0] cmd, input logic [2:0] off, input bit cmp,
         input int m_at, input bit same);
      exp_cmd = cmd; exp_off = int'(off); exp_cmp = cmp; match_at = m_at;
      same_ack = same; tries = 0; tx_bad = 0; gap_bad = 0; tran_bad = 0;
      cs_hi_seen = 1'b1;
   endtask

   task automatic finish_run(input logic [7:0] cmd, input logic [3:0] tmo,
         input logic [2:0] off, input bit cmp, input int cs, input int m_at);
      int budget = budget_of(cs, int'(tmo));
      bit matched = (m_at >= 1 && m_at <= budget);
      int exp_tries = matched ? m_at : budget;
      logic [2:0] exp_stat = {~matched, matched, 1'b1};
      while (cfg_rd[31]) @(negedge clk);
      @(negedge clk);
      check(tries == exp_tries, matched ? "R3 tries until match" : "R4 tries in budget",
            tries, exp_tries);
      check(int_stat == exp_stat, matched ? "R3 match status" : "R4 timeout status",
            int'(int_stat), int'(exp_stat));
      check(tran_bad == 0, "R5 try-done per try", tran_bad, 0);
      check(gap_bad == 0, "R6 select gap", gap_bad, 0);
      check(tx_bad == 0, "R2 command per try", tx_bad, 0);
      check(irq == |(exp_stat & ~int_mask), "R8 masked irq", int'(irq),
            int'(|(exp_stat & ~int_mask)));
      check(cfg_rd == pack_word(1'b0, cmp, off, tmo, cmd), "R2 readback",
            int'(cfg_rd), int'(pack_word(1'b0, cmp, off, tmo, cmd)));
      ack_main = 3'b111;
      @(negedge clk);
      ack_main = 3'b000;
      check(int_stat == 3'b000, "R9 ack clears", int'(int_stat), 0);
   endtask

   task automatic run_poll(input logic [7:0] cmd, input logic [3:0] tmo,
         input logic [2:0] off, input bit cmp, input int cs, input int m_at,
         input bit same, input logic [2:0] mask);
      prime(cmd, off, cmp, m_at, same);
      clk_sel = 3'(cs);
      int_mask = mask;
      write_cfg(pack_word(1'b1, cmp, off, tmo, cmd));
      finish_run(cmd, tmo, off, cmp, cs, m_at);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      prime(8'h00, 3'd0, 1'b0, 0, 1'b0);
      repeat (3) @(negedge clk);
      check(cs_n == 1'b1 && xfer_start == 1'b0, "R1 reset select", int'(cs_n), 1);
      check(int_stat == 3'b000 && irq == 1'b0, "R1 reset status", int'(int_stat), 0);
      check(cfg_rd == 32'h0, "R1 reset readback", int'(cfg_rd), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: write without start while idle
      prime(8'h00, 3'd0, 1'b0, 0, 1'b0);
      write_cfg(pack_word(1'b0, 1'b1, 3'd5, 4'd2, 8'hA7));
      repeat (10) @(negedge clk);
      check(tries == 0, "R10 no try started", tries, 0);
      check(cfg_rd == pack_word(1'b0, 1'b1, 3'd5, 4'd2, 8'hA7), "R10 fields stored",
            int'(cfg_rd), int'(pack_word(1'b0, 1'b1, 3'd5, 4'd2, 8'hA7)));

      // Directed: match on first try, on last try, never (timeout)
      run_poll(8'h05, 4'd0, 3'd0, 1'b0, 0, 1, 1'b0, 3'b000);
      run_poll(8'h9F, 4'd0, 3'd7, 1'b1, 0, 31, 1'b0, 3'b001);
      run_poll(8'h3C, 4'd1, 3'd3, 1'b0, 0, 0, 1'b0, 3'b100);
      run_poll(8'h11, 4'd0, 3'd1, 1'b1, 1, 0, 1'b0, 3'b011);

      // R9: acknowledge in the same cycle as events, including final match
      run_poll(8'h42, 4'd0, 3'd2, 1'b1, 0, 7, 1'b1, 3'b000);
      run_poll(8'h43, 4'd0, 3'd6, 1'b0, 0, 0, 1'b1, 3'b000);

      // R7: start during a run is ignored
      prime(8'h6B, 3'd4, 1'b1, 0, 1'b0);
      clk_sel = 3'd0;
      int_mask = 3'b000;
      write_cfg(pack_word(1'b1, 1'b1, 3'd4, 4'd1, 8'h6B));
      while (tries < 3) @(negedge clk);
      write_cfg(pack_word(1'b1, 1'b0, 3'd1, 4'd3, 8'hEE));
      @(negedge clk);
      check(cfg_rd == pack_word(1'b1, 1'b1, 3'd4, 4'd1, 8'h6B), "R7 fields held",
            int'(cfg_rd), int'(pack_word(1'b1, 1'b1, 3'd4, 4'd1, 8'h6B)));
      finish_run(8'h6B, 4'd1, 3'd4, 1'b1, 0, 0);

      // Constrained random runs
      for (int n = 0; n < 14; n++) begin
         int cs = $urandom_range(0, 2);
         int tm = $urandom_range(0, 3 - cs);
         int b = budget_of(cs, tm);
         int m = $urandom_range(0, b + 2);
         run_poll(8'($urandom), 4'(tm), 3'($urandom), 1'($urandom), cs, m,
                  1'($urandom), 3'($urandom));
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule